// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading page table entries from memory on its own. When a walk is started, it captures the virtual address and the base of the top-level table. It reads one 32-bit entry from the top-level table and, if that entry is valid, reads one entry from the second-level table that the first entry points to. Pages are 4 KB, so each table holds 1024 entries. The virtual address is split into a 10-bit top index (bits 31:22), a 10-bit second index (bits 21:12) and a 12-bit page offset (bits 11:0).

An entry keeps its frame or next-table address in bits 31:12. Bit 0 is the valid flag, bit 1 is the used flag and bit 2 is the dirty flag. If the entry at either level is invalid, the walk ends with a page-fault status, and the status reports which level failed. If the leaf entry is valid, the walk returns the frame number, the full physical address and the entry's used and dirty flags. Memory is reached through a request pulse that carries an address and a response strobe that carries the data. Only one read is ever outstanding, and the response may arrive any number of cycles after the request.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req_valid`, `walk_done` and `walk_fault` are all 0.
- R2: The first memory request is issued in the cycle after `walk_start` is accepted, and its address is `root_base + walk_vaddr[31:22]*4`.
- R3: The second request is issued in the cycle after a valid first-level response arrives. Its address is `{entry[31:12], 12'h000} + walk_vaddr[21:12]*4`.
- R4: A second-level entry with bit 0 set ends the walk with `walk_done`=1 and `walk_fault`=0. At the same time, `res_frame` = entry[31:12], `res_paddr` = {entry[31:12], walk_vaddr[11:0]}, `res_used` = entry bit 1 and `res_dirty` = entry bit 2.
- R5: A first-level entry with bit 0 clear ends the walk with `walk_done`=1, `walk_fault`=1 and `fault_lvl`=0, and no second request is made. `res_frame`, `res_used` and `res_dirty` read 0.
- R6: A second-level entry with bit 0 clear ends the walk with `walk_done`=1, `walk_fault`=1 and `fault_lvl`=1, after exactly two requests.
- R7: `walk_start` is ignored while `busy` is 1. The walk in progress keeps its address and table base, and no extra request is made.
- R8: `walk_done` is high for exactly one cycle per walk. `mem_req_valid` is a one-cycle pulse, and no new request is made while a response is still owed.
- R9: `mem_rsp_valid` has no effect unless a response is being awaited. A stray response while idle changes no output.
- R10: The walker waits any number of cycles for each response, and the result does not depend on the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| walk_start | input | 1 | Start a walk (accepted only when idle) |
| walk_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry returned by memory |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| walk_fault | output | 1 | Walk ended in a page fault (valid with walk_done) |
| fault_lvl | output | 1 | Level that faulted: 0 top, 1 second |
| res_frame | output | 20 | Physical frame number of the last walk |
| res_paddr | output | 32 | Physical address of the last walk |
| res_used | output | 1 | Used flag of the leaf entry |
| res_dirty | output | 1 | Dirty flag of the leaf entry |

## Verification
The hardest situations to reach from the ports are a new start that arrives while a response is still owed, and a response strobe that arrives when none is expected. The memory model in the bench can stretch its response latency, so the bench can raise `walk_start` with a different address in the middle of a long wait and then confirm that the original translation comes back after exactly two requests. With the model switched off, the bench injects response strobes directly while the walker is idle. It then checks that the held result outputs and the request line do not move.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    parameter int unsigned VA_W      = 32;
    parameter int unsigned OFF_W     = 12;
    parameter int unsigned IDX_W     = 10;
    parameter int unsigned ENT_SHIFT = 2;
    localparam int unsigned FRAME_W  = VA_W - OFF_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_L1 = 3'd1,
        ST_WT_L1 = 3'd2,
        ST_RD_L2 = 3'd3,
        ST_WT_L2 = 3'd4,
        ST_DONE  = 3'd5,
        ST_FLT   = 3'd6
    } walk_st_e;

    typedef struct packed {
        walk_st_e               st;
        logic [VA_W-1:0]        va;
        logic [VA_W-1:0]        tbase;
        logic [FRAME_W-1:0]     frame;
        logic                   used;
        logic                   dirty;
        logic                   flvl;
    } walk_regs_t;

endpackage

// File: rtl/pt_walker_ent_addr.sv
module pt_walker_ent_addr #(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned ENT_SHIFT = 2
) (
    input  logic [VA_W-1:0]  tbl_base,
    input  logic [IDX_W-1:0] tbl_idx,
    output logic [VA_W-1:0]  ent_addr
);
    localparam int unsigned ENT_BYTES = 1 << ENT_SHIFT;

    logic [VA_W-1:0] byte_off;

    always_comb begin
        byte_off = VA_W'(tbl_idx) * VA_W'(ENT_BYTES);
        ent_addr = tbl_base + byte_off;
    end
endmodule

// File: rtl/pt_walker_ent_dec.sv
module pt_walker_ent_dec #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic [VA_W-1:0]       ent,
    output logic                  ent_valid,
    output logic                  ent_used,
    output logic                  ent_dirty,
    output logic [VA_W-OFF_W-1:0] ent_frame
);
    localparam int unsigned VALID_BIT = 0;
    localparam int unsigned USED_BIT  = 1;
    localparam int unsigned DIRTY_BIT = 2;

    logic unused_ent_bits;

    always_comb begin
        ent_valid       = ent[VALID_BIT];
        ent_used        = ent[USED_BIT];
        ent_dirty       = ent[DIRTY_BIT];
        ent_frame       = ent[VA_W-1:OFF_W];
        unused_ent_bits = ^ent[OFF_W-1:DIRTY_BIT+1];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned P_VA_W  = pt_walker_pkg::VA_W,
    parameter int unsigned P_OFF_W = pt_walker_pkg::OFF_W,
    parameter int unsigned P_IDX_W = pt_walker_pkg::IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      walk_start,
    input  logic [P_VA_W-1:0]         walk_vaddr,
    input  logic [P_VA_W-1:0]         root_base,
    output logic                      busy,
    output logic                      mem_req_valid,
    output logic [P_VA_W-1:0]         mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [P_VA_W-1:0]         mem_rsp_data,
    output logic                      walk_done,
    output logic                      walk_fault,
    output logic                      fault_lvl,
    output logic [P_VA_W-P_OFF_W-1:0] res_frame,
    output logic [P_VA_W-1:0]         res_paddr,
    output logic                      res_used,
    output logic                      res_dirty
);
    localparam int unsigned TOP_LSB = P_OFF_W + P_IDX_W;

    walk_regs_t q, d;

    logic [P_IDX_W-1:0]         cur_idx;
    logic [P_VA_W-1:0]          ent_addr;
    logic                       ent_valid;
    logic                       ent_used;
    logic                       ent_dirty;
    logic [P_VA_W-P_OFF_W-1:0]  ent_frame;

    always_comb begin
        if (q.st == ST_RD_L1) cur_idx = q.va[TOP_LSB +: P_IDX_W];
        else                  cur_idx = q.va[P_OFF_W +: P_IDX_W];
    end

    pt_walker_ent_addr #(
        .VA_W      (P_VA_W),
        .IDX_W     (P_IDX_W),
        .ENT_SHIFT (ENT_SHIFT)
    ) u_addr (
        .tbl_base (q.tbase),
        .tbl_idx  (cur_idx),
        .ent_addr (ent_addr)
    );

    pt_walker_ent_dec #(
        .VA_W  (P_VA_W),
        .OFF_W (P_OFF_W)
    ) u_dec (
        .ent       (mem_rsp_data),
        .ent_valid (ent_valid),
        .ent_used  (ent_used),
        .ent_dirty (ent_dirty),
        .ent_frame (ent_frame)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (walk_start) begin
                    d.st    = ST_RD_L1;
                    d.va    = walk_vaddr;
                    d.tbase = root_base;
                end
            end
            ST_RD_L1: d.st = ST_WT_L1;
            ST_WT_L1: begin
                if (mem_rsp_valid) begin
                    if (ent_valid) begin
                        d.st    = ST_RD_L2;
                        d.tbase = {ent_frame, {P_OFF_W{1'b0}}};
                    end else begin
                        d.st    = ST_FLT;
                        d.flvl  = 1'b0;
                        d.frame = '0;
                        d.used  = 1'b0;
                        d.dirty = 1'b0;
                    end
                end
            end
            ST_RD_L2: d.st = ST_WT_L2;
            ST_WT_L2: begin
                if (mem_rsp_valid) begin
                    if (ent_valid) begin
                        d.st    = ST_DONE;
                        d.flvl  = 1'b0;
                        d.frame = ent_frame;
                        d.used  = ent_used;
                        d.dirty = ent_dirty;
                    end else begin
                        d.st    = ST_FLT;
                        d.flvl  = 1'b1;
                        d.frame = '0;
                        d.used  = 1'b0;
                        d.dirty = 1'b0;
                    end
                end
            end
            ST_DONE, ST_FLT: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy          = (q.st != ST_IDLE);
        mem_req_valid = (q.st == ST_RD_L1) || (q.st == ST_RD_L2);
        mem_req_addr  = ent_addr;
        walk_done     = (q.st == ST_DONE) || (q.st == ST_FLT);
        walk_fault    = (q.st == ST_FLT);
        fault_lvl     = q.flvl;
        res_frame     = q.frame;
        res_paddr     = {q.frame, q.va[P_OFF_W-1:0]};
        res_used      = q.used;
        res_dirty     = q.dirty;
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned IDX_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            walk_start,
    input logic [VA_W-1:0] walk_vaddr,
    input logic [VA_W-1:0] root_base,
    input logic            busy,
    input logic            mem_req_valid,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            walk_done,
    input logic            walk_fault
);
    logic owed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             owed_q <= 1'b0;
        else if (mem_req_valid) owed_q <= 1'b1;
        else if (mem_rsp_valid) owed_q <= 1'b0;
    end

    assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !walk_done));

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(walk_start && !busy)) |->
        (mem_req_addr == $past(root_base) + (VA_W'($past(walk_vaddr) >> (VA_W - IDX_W)) << 2)));

    assert_fault_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_fault |-> walk_done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !owed_q);

    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
endmodule

bind pt_walker pt_walker_chk #(
    .VA_W  (P_VA_W),
    .IDX_W (P_IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_start    (walk_start),
    .walk_vaddr    (walk_vaddr),
    .root_base     (root_base),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .walk_done     (walk_done),
    .walk_fault    (walk_fault)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] root;
        logic [31:0] l1e;
        logic [31:0] l2e;
        logic [7:0]  lat;
        logic        efault;
        logic        elvl;
        logic [31:0] epaddr;
        logic        eused;
        logic        edirty;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0040_1ABC, 32'h0010_0000, 32'h0020_0001, 32'h1234_5007, 8'd0, 1'b0, 1'b0, 32'h1234_5ABC, 1'b1, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0003_0001, 32'hABCD_E001, 8'd3, 1'b0, 1'b0, 32'hABCD_EFFF, 1'b0, 1'b0},
        '{32'h0000_0000, 32'h0800_0000, 32'h0000_0000, 32'h0000_0000, 8'd1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h1234_5678, 32'h0000_2000, 32'h0040_0001, 32'h5555_5002, 8'd2, 1'b1, 1'b1, 32'h0000_0678, 1'b0, 1'b0},
        '{32'h8000_3010, 32'h0000_1000, 32'h0ABC_D003, 32'h0007_7003, 8'd5, 1'b0, 1'b0, 32'h0007_7010, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_start = 1'b0;
    logic [31:0] walk_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        busy, mem_req_valid, walk_done, walk_fault, fault_lvl;
    logic [31:0] mem_req_addr, res_paddr;
    logic [19:0] res_frame;
    logic        res_used, res_dirty;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    logic        mdl_valid = 1'b0;
    logic [31:0] mdl_data = '0;
    logic        inj_valid = 1'b0;
    logic [31:0] inj_data = '0;
    logic        mdl_on = 1'b1;
    int          mdl_lat = 0;
    int          req_cnt = 0;
    logic [31:0] req_addr [4];
    logic [31:0] mem_img [logic [31:0]];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    assign mem_rsp_valid = mdl_valid | inj_valid;
    assign mem_rsp_data  = inj_valid ? inj_data : mdl_data;

    always #5 clk = ~clk;

    pt_walker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .walk_start    (walk_start),
        .walk_vaddr    (walk_vaddr),
        .root_base     (root_base),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .walk_done     (walk_done),
        .walk_fault    (walk_fault),
        .fault_lvl     (fault_lvl),
        .res_frame     (res_frame),
        .res_paddr     (res_paddr),
        .res_used      (res_used),
        .res_dirty     (res_dirty)
    );

    // memory model: sees requests at the falling edge, answers after 1+lat cycles
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            mdl_valid = 1'b0;
            if (mdl_on && mem_req_valid) begin
                a = mem_req_addr;
                if (req_cnt < 4) req_addr[req_cnt] = a;
                req_cnt++;
                repeat (mdl_lat + 1) @(negedge clk);
                mdl_data  = mem_img.exists(a) ? mem_img[a] : 32'h0;
                mdl_valid = 1'b1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic start_walk(input logic [31:0] va, input logic [31:0] root);
        @(negedge clk);
        walk_vaddr = va;
        root_base  = root;
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int c = 0; c < 300 && !walk_done; c++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] l2a;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy, "R1 busy", 32'(busy), 0);
        chk(!mem_req_valid, "R1 req", 32'(mem_req_valid), 0);
        chk(!walk_done && !walk_fault, "R1 done", 32'(walk_done), 0);
        rst_n = 1'b1;

        // R2..R6, R10: vector walks with different latencies
        for (int i = 0; i < NVEC; i++) begin
            mem_img.delete();
            mem_img[VEC[i].root + {20'h0, VEC[i].va[31:22], 2'b00}] = VEC[i].l1e;
            l2a = {VEC[i].l1e[31:12], 12'h000} + {20'h0, VEC[i].va[21:12], 2'b00};
            if (VEC[i].l1e[0]) mem_img[l2a] = VEC[i].l2e;
            mdl_lat = int'(VEC[i].lat);
            req_cnt = 0;
            start_walk(VEC[i].va, VEC[i].root);
            wait_done();
            chk(walk_done, "R10 done seen", 32'(walk_done), 1);
            chk(req_addr[0] == VEC[i].root + {20'h0, VEC[i].va[31:22], 2'b00}, "R2 l1 addr",
                req_addr[0], VEC[i].root + {20'h0, VEC[i].va[31:22], 2'b00});
            if (VEC[i].l1e[0]) begin
                chk(req_addr[1] == l2a, "R3 l2 addr", req_addr[1], l2a);
                chk(req_cnt == 2, "R6 req count", 32'(req_cnt), 2);
            end else begin
                chk(req_cnt == 1, "R5 req count", 32'(req_cnt), 1);
            end
            chk(walk_fault == VEC[i].efault, "R4 fault", 32'(walk_fault), 32'(VEC[i].efault));
            if (VEC[i].efault)
                chk(fault_lvl == VEC[i].elvl, "R6 level", 32'(fault_lvl), 32'(VEC[i].elvl));
            chk(res_paddr == VEC[i].epaddr, "R4 paddr", res_paddr, VEC[i].epaddr);
            chk(res_frame == VEC[i].epaddr[31:12], "R4 frame", 32'(res_frame), 32'(VEC[i].epaddr[31:12]));
            chk(res_used == VEC[i].eused && res_dirty == VEC[i].edirty, "R4 flags",
                {30'h0, res_dirty, res_used}, {30'h0, VEC[i].edirty, VEC[i].eused});
            @(negedge clk);
            chk(!walk_done && !busy, "R8 done width", {30'h0, busy, walk_done}, 0);
        end

        // R7: start pulsed mid-walk with another address
        mem_img.delete();
        mem_img[32'h0010_0004] = 32'h0020_0001;
        mem_img[32'h0020_0004] = 32'h1234_5007;
        mdl_lat = 8;
        req_cnt = 0;
        start_walk(32'h0040_1ABC, 32'h0010_0000);
        repeat (2) @(negedge clk);
        walk_vaddr = 32'hFFFF_FFFF;
        root_base  = 32'h0;
        walk_start = 1'b1;
        repeat (2) @(negedge clk);
        walk_start = 1'b0;
        wait_done();
        chk(res_paddr == 32'h1234_5ABC && !walk_fault, "R7 paddr", res_paddr, 32'h1234_5ABC);
        chk(req_addr[0] == 32'h0010_0004, "R7 l1 addr", req_addr[0], 32'h0010_0004);
        repeat (6) @(negedge clk);
        chk(req_cnt == 2, "R7 req count", 32'(req_cnt), 2);

        // R9: stray responses while idle
        mdl_on = 1'b0;
        held = res_paddr;
        req_cnt = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            inj_valid = 1'b1;
            inj_data  = 32'hDEAD_B007;
        end
        @(negedge clk);
        inj_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !walk_done && !mem_req_valid, "R9 idle", {29'h0, busy, walk_done, mem_req_valid}, 0);
        chk(res_paddr == held, "R9 result held", res_paddr, held);
        chk(res_used && res_dirty, "R9 flags held", {30'h0, res_dirty, res_used}, 3);
        mdl_on = 1'b1;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule